// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Unit

This block runs one external bus transfer at a time for a 16-bit processor core with a 20-bit physical address. The address, the data and a set of status bits share one group of bus lines. A transfer splits into four phases, T1 to T4. In T1 the full address is driven and an address-latch strobe pulses. From T2 the upper lines carry status bits and the lower lines carry data. The read and write strobes are active in T2, T3 and any wait states. The core sees the result as a one-clock completion pulse in T4, with the captured read data beside it.

The core holds `reqValid` high until `cycleDone` pulses. Between transfers the block samples a bus-hold request from another master. When it grants the bus, it stops driving every bus line and every control line until the request goes away. Tri-state behaviour is modelled with output-enable signals, and read data arrives on a separate input.

Top module: `mux_bus_unit`

## Requirements
- R1: After reset `hlda`, `ale`, `lowOe`, `highOe` and `cycleDone` are 0, `rdN`, `wrN` and `denN` are 1, and `ctlOe` is 1.
- R2: The clock after a request is accepted from idle is T1. In T1 `ale` is 1 for exactly that clock, `adOut[19:0]` equals the 20-bit request address, and `lowOe` and `highOe` are both 1.
- R3: From T2 through T4, `adOut[19]` is 0, `adOut[18]` equals the interrupt-enable input latched with the request, and `adOut[17:16]` equals the latched segment code (00 extra, 01 stack, 10 code, 11 data). `highOe` is 1 during these phases.
- R4: In a read, `rdN` is 0 in T2, T3 and every wait state. `lowOe` is 0 from T2 through T4, `dtR` is 0, and `denN` is 0 while `rdN` is 0.
- R5: In a write, `wrN` is 0 in T2, T3 and every wait state. `adOut[15:0]` carries the write data with `lowOe` 1 from T2 through T4, and `dtR` is 1.
- R6: `mIo` is 1 for a memory transfer and 0 for an I/O transfer, from T1 on.
- R7: `ready` is sampled at the end of T3 and at the end of each wait state. Each low sample adds one wait-state clock with the strobes held, so a transfer lasts 4 plus the wait count clocks.
- R8: Read data on `adIn` is captured at the clock edge that ends the last T3 or wait state. It is shown on `rdData` while `cycleDone` pulses for one clock in T4.
- R9: `hold` is sampled only in idle. `hlda` rises one clock after `hold` is seen there and never during a transfer. While `hlda` is 1, `lowOe`, `highOe` and `ctlOe` are all 0.
- R10: `hlda` falls one clock after `hold` falls. A request present together with `hold` in idle waits until the hold ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Core requests a transfer; held until cycleDone |
| reqWrite | input | 1 | 1 write, 0 read |
| reqIo | input | 1 | 1 I/O space, 0 memory space |
| reqAddr | input | 20 | Physical address |
| reqWdata | input | 16 | Write data |
| reqSeg | input | 2 | Segment code of the address source |
| intEnable | input | 1 | Interrupt-enable flag reported as status |
| cycleDone | output | 1 | One-clock pulse in T4 |
| rdData | output | 16 | Captured read data |
| adOut | output | 20 | Value driven on the shared lines |
| adIn | input | 16 | Value seen on the lower shared lines |
| lowOe | output | 1 | Enable for lines 15:0 |
| highOe | output | 1 | Enable for lines 19:16 |
| ctlOe | output | 1 | Enable for the control strobes |
| ale | output | 1 | Address-latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| mIo | output | 1 | 1 memory, 0 I/O |
| dtR | output | 1 | Transceiver direction, 1 transmit |
| denN | output | 1 | Transceiver enable, active low |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
The bench builds the block with its default widths: 20 address lines and 16 data lines, which leaves exactly four status lines. With this shape, a single vector covers every bit of the status field, and the address extremes 0x00000 and 0xFFFFF reach the upper lines. The vectors combine reads and writes, memory and I/O, all four segment codes, and zero to three wait states. Directed runs then request hold in idle, request hold in the middle of a transfer, and request hold together with a pending transfer.

// File: rtl/adbus_pkg.sv
package adbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_HOLD
  } busState_t;

  typedef struct packed {
    logic load;       // latch request (idle -> T1)
    logic addrPhase;  // T1
    logic dataPhase;  // T2, T3, wait states
    logic lastPhase;  // T4
    logic strobe;     // read/write strobe window
    logic capture;    // take read data at this edge
    logic floatBus;   // bus granted away
  } busStrobe_t;
endpackage

// File: rtl/adbus_ctrl.sv
module adbus_ctrl
  import adbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ready,
  input  logic       hold,
  output busStrobe_t stb,
  output logic       hlda,
  output logic       cycleDone
);
  busState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (hold) nextState = ST_HOLD;
               else if (reqValid) nextState = ST_T1;
      ST_T1:   nextState = ST_T2;
      ST_T2:   nextState = ST_T3;
      ST_T3:   nextState = ready ? ST_T4 : ST_TW;
      ST_TW:   nextState = ready ? ST_T4 : ST_TW;
      ST_T4:   nextState = ST_IDLE;
      ST_HOLD: if (!hold) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb.load      = (state == ST_IDLE) && !hold && reqValid;
    stb.addrPhase = (state == ST_T1);
    stb.dataPhase = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
    stb.lastPhase = (state == ST_T4);
    stb.strobe    = stb.dataPhase;
    stb.capture   = ((state == ST_T3) || (state == ST_TW)) && ready;
    stb.floatBus  = (state == ST_HOLD);
  end

  assign hlda      = (state == ST_HOLD);
  assign cycleDone = (state == ST_T4);

  p_grant_follows_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hlda) |-> $past(hold));
  p_release_one_clock_r10: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && !hold) |=> !hlda);
  p_wait_holds_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dataPhase && (state != ST_T2) && !ready) |=> stb.dataPhase);
  p_no_grant_in_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.addrPhase || stb.dataPhase) |=> !hlda);
endmodule

// File: rtl/adbus_dp.sv
module adbus_dp
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        stb,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic              intEnable,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] adOut,
  output logic              lowOe,
  output logic              highOe,
  output logic              ctlOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              mIo,
  output logic              dtR,
  output logic              denN
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic              curWrite, curIo, curIe;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic [SEG_W-1:0]  curSeg;
  logic [HI_W-1:0]   statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curIo    <= 1'b0;
      curIe    <= 1'b0;
      curAddr  <= '0;
      curWdata <= '0;
      curSeg   <= '0;
    end else if (stb.load) begin
      curWrite <= reqWrite;
      curIo    <= reqIo;
      curIe    <= intEnable;
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curSeg   <= reqSeg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (stb.capture) rdData <= adIn;
  end

  // top status bit stays 0, then interrupt enable, then segment code
  assign statusWord = HI_W'({1'b0, curIe, curSeg});

  always_comb begin
    adOut  = stb.addrPhase ? curAddr : {statusWord, curWdata};
    lowOe  = stb.addrPhase || ((stb.dataPhase || stb.lastPhase) && curWrite);
    highOe = stb.addrPhase || stb.dataPhase || stb.lastPhase;
    ctlOe  = !stb.floatBus;
    ale    = stb.addrPhase;
    rdN    = !(stb.strobe && !curWrite);
    wrN    = !(stb.strobe && curWrite);
    denN   = !stb.strobe;
    mIo    = !curIo;
    dtR    = curWrite;
  end

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_read_lines_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !lowOe);
  p_write_data_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && $past(!wrN)) |-> $stable(adOut));
  p_capture_needs_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture && !curWrite) |-> !rdN);
endmodule

// File: rtl/mux_bus_unit.sv
module mux_bus_unit
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic              intEnable,
  output logic              cycleDone,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              lowOe,
  output logic              highOe,
  output logic              ctlOe,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              mIo,
  output logic              dtR,
  output logic              denN,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);
  busStrobe_t stb;

  adbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready), .hold(hold),
    .stb(stb), .hlda(hlda), .cycleDone(cycleDone)
  );

  adbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqWrite(reqWrite), .reqIo(reqIo), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqSeg(reqSeg), .intEnable(intEnable), .adIn(adIn), .rdData(rdData),
    .adOut(adOut), .lowOe(lowOe), .highOe(highOe), .ctlOe(ctlOe), .ale(ale),
    .rdN(rdN), .wrN(wrN), .mIo(mIo), .dtR(dtR), .denN(denN)
  );

  p_granted_bus_floats_r9: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!lowOe && !highOe && !ctlOe));
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cycleDone) |-> $past(!rdN || !wrN));
endmodule

// File: tb/mux_bus_unit_tb.sv
`timescale 1ns/1ps
module mux_bus_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0, intEnable = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, adIn = '0;
  logic [1:0]  reqSeg = '0;
  logic        ready = 1'b1, hold = 1'b0;
  logic        cycleDone, lowOe, highOe, ctlOe, ale, rdN, wrN, mIo, dtR, denN, hlda;
  logic [15:0] rdData;
  logic [19:0] adOut;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  mux_bus_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqIo(reqIo),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqSeg(reqSeg), .intEnable(intEnable),
    .cycleDone(cycleDone), .rdData(rdData), .adOut(adOut), .adIn(adIn),
    .lowOe(lowOe), .highOe(highOe), .ctlOe(ctlOe), .ale(ale), .rdN(rdN), .wrN(wrN),
    .mIo(mIo), .dtR(dtR), .denN(denN), .ready(ready), .hold(hold), .hlda(hlda)
  );

  typedef struct packed {
    logic        wr;
    logic        io;
    logic [19:0] addr;
    logic [15:0] wdata;
    logic [1:0]  seg;
    logic        ie;
    logic [2:0]  waits;
    logic [15:0] rdval;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{wr:1'b0, io:1'b0, addr:20'hABCDE, wdata:16'h0000, seg:2'b10, ie:1'b1, waits:3'd0, rdval:16'h1234},
    '{wr:1'b1, io:1'b0, addr:20'h12345, wdata:16'hBEEF, seg:2'b11, ie:1'b0, waits:3'd0, rdval:16'h0000},
    '{wr:1'b0, io:1'b1, addr:20'h003F8, wdata:16'h0000, seg:2'b11, ie:1'b1, waits:3'd2, rdval:16'hA5C3},
    '{wr:1'b1, io:1'b1, addr:20'h00060, wdata:16'h00FF, seg:2'b00, ie:1'b0, waits:3'd1, rdval:16'h0000},
    '{wr:1'b0, io:1'b0, addr:20'hFFFFF, wdata:16'h0000, seg:2'b01, ie:1'b0, waits:3'd3, rdval:16'hFFFF},
    '{wr:1'b1, io:1'b0, addr:20'h00000, wdata:16'h8001, seg:2'b01, ie:1'b1, waits:3'd0, rdval:16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic runCycle(input vec_t v);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = v.wr; reqIo = v.io; reqAddr = v.addr;
    reqWdata = v.wdata; reqSeg = v.seg; intEnable = v.ie;
    adIn = v.rdval; ready = 1'b1;
    @(negedge clk); // T1
    reqValid = 1'b0; intEnable = ~v.ie; reqSeg = ~v.seg; // latched values must win
    check("R2 ale in T1", {31'd0, ale}, 32'd1);
    check("R2 address lines", {12'd0, adOut}, {12'd0, v.addr});
    check("R2 line enables", {30'd0, lowOe, highOe}, 32'd3);
    check("R6 mIo", {31'd0, mIo}, {31'd0, !v.io});
    @(negedge clk); // T2
    check("R2 ale one clock", {31'd0, ale}, 32'd0);
    check("R3 status lines", {28'd0, adOut[19:16]}, {28'd0, 1'b0, v.ie, v.seg});
    check("R3 highOe", {31'd0, highOe}, 32'd1);
    if (v.wr) begin
      check("R5 wrN/rdN", {30'd0, wrN, rdN}, 32'd1);
      check("R5 write data", {16'd0, adOut[15:0]}, {16'd0, v.wdata});
      check("R5 lowOe/dtR", {30'd0, lowOe, dtR}, 32'd3);
    end else begin
      check("R4 rdN/wrN", {30'd0, rdN, wrN}, 32'd1);
      check("R4 lowOe/dtR/denN", {29'd0, lowOe, dtR, denN}, 32'd0);
    end
    @(negedge clk); // T3
    ready = (v.waits == 0);
    check("R7 strobe in T3", {30'd0, rdN, wrN}, v.wr ? 32'd2 : 32'd1);
    for (int k = 0; k < int'(v.waits); k++) begin
      @(negedge clk); // wait state
      ready = (k == int'(v.waits) - 1);
      check("R7 strobe held in wait", {30'd0, rdN, wrN}, v.wr ? 32'd2 : 32'd1);
      check("R7 no done in wait", {31'd0, cycleDone}, 32'd0);
    end
    @(negedge clk); // T4
    adIn = 16'h0F0F;
    check("R8 done pulse", {31'd0, cycleDone}, 32'd1);
    check("R7 strobes off in T4", {29'd0, rdN, wrN, denN}, 32'd7);
    check("R3 status in T4", {28'd0, adOut[19:16]}, {28'd0, 1'b0, v.ie, v.seg});
    if (v.wr) check("R5 data held T4", {15'd0, lowOe, adOut[15:0]}, {15'd0, 1'b1, v.wdata});
    else      check("R8 read data", {16'd0, rdData}, {16'd0, v.rdval});
    @(negedge clk); // idle
    ready = 1'b1;
    check("R8 done one clock", {31'd0, cycleDone}, 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset low outputs", {26'd0, hlda, ale, lowOe, highOe, cycleDone, 1'b0}, 32'd0);
    check("R1 reset high outputs", {28'd0, rdN, wrN, denN, ctlOe}, 32'hF);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {30'd0, ale, hlda}, 32'd0);

    for (int i = 0; i < NVEC; i++) runCycle(VECS[i]);

    // R9: hold in idle
    @(negedge clk);
    hold = 1'b1;
    #1 check("R9 no grant before edge", {31'd0, hlda}, 32'd0);
    @(negedge clk);
    check("R9 grant one clock later", {31'd0, hlda}, 32'd1);
    check("R9 bus floats", {29'd0, lowOe, highOe, ctlOe}, 32'd0);
    // R10: request during hold waits
    reqValid = 1'b1; reqWrite = 1'b0; reqIo = 1'b0; reqAddr = 20'h54321;
    reqSeg = 2'b00; intEnable = 1'b0; adIn = 16'h7777;
    @(negedge clk);
    check("R10 request waits under hold", {30'd0, ale, hlda}, 32'd1);
    hold = 1'b0;
    @(negedge clk);
    check("R10 release one clock later", {31'd0, hlda}, 32'd0);
    check("R10 no T1 yet", {31'd0, ale}, 32'd0);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 pending request starts", {12'd0, ale, adOut}, {12'd0, 1'b1, 20'h54321});
    repeat (3) @(negedge clk);
    check("R10 pending read completes", {15'd0, cycleDone, rdData}, {15'd0, 1'b1, 16'h7777});

    // R9: hold raised mid-cycle is deferred
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 20'h0A0A0; reqWdata = 16'h1111;
    @(negedge clk); // T1
    reqValid = 1'b0;
    @(negedge clk); // T2
    hold = 1'b1;
    @(negedge clk); // T3
    check("R9 no grant in T3", {30'd0, hlda, wrN}, 32'd0);
    @(negedge clk); // T4
    check("R9 no grant in T4", {30'd0, hlda, cycleDone}, 32'd1);
    @(negedge clk); // idle, hold sampled here
    check("R9 no grant in idle clock", {31'd0, hlda}, 32'd0);
    @(negedge clk);
    check("R9 grant after cycle", {30'd0, hlda, ctlOe}, 32'd2);
    hold = 1'b0;
    @(negedge clk);
    check("R10 released", {30'd0, hlda, ctlOe}, 32'd1);

    finishRun();
  end
endmodule